// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs single read and write cycles on an external bus where address and data share one set of pins. A CPU-side request (address, write data, direction, window number) is taken when the sequencer is idle. The block then drives the address with an address latch enable (ALE) strobe, holds the address, and pulses a read or write strobe. A write puts its data on the bus during that strobe. A read leaves the bus undriven so that the external device can answer. At the end of the cycle the block returns the read data together with a one-tick done pulse.

The block runs on a phase clock at twice the CPU clock rate. One tick is therefore half a CPU clock, which lets edges be placed at half-clock resolution. Each address window has a one-bit ALE-lengthening setting. When it is set, ALE stays high half a CPU clock longer and the address hold after ALE also grows by half a CPU clock. As a result the strobe and data transfer come one full CPU clock later.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the block is idle. busy, done and ale are 0, rd_n and wr_n are 1, and bus_oe is 0.
- R2: After reset, window 0 has ALE lengthening enabled and every other window has it disabled. A pulse on cfg_we loads cfg_alelong into the setting of window cfg_win.
- R3: An unstretched cycle runs four phases in order: ALE high for 2 ticks, address hold for 2 ticks, strobe low for 2 ticks, then recovery for 2 ticks.
- R4: A stretched cycle has ALE high for 3 ticks and address hold for 3 ticks, so its strobe starts 2 ticks (one CPU clock) later than in an unstretched cycle. The strobe and recovery phases keep their normal lengths.
- R5: A cycle uses the window setting in force at the tick it is accepted. A configuration write made during a cycle affects only later cycles.
- R6: bus_o carries the request address with bus_oe high during ALE and address hold. For a read, bus_oe is low from the start of the strobe phase until the cycle ends.
- R7: For a write, bus_o carries the write data with bus_oe high from the start of the strobe until one tick after wr_n rises. bus_oe is low after that.
- R8: Read data is taken from bus_i on the clock edge where rd_n rises. It is presented on rdata when done pulses for one tick, in the first tick after recovery, which is also the tick in which busy falls.
- R9: busy is high from the acceptance edge until done. A request made while busy is ignored and starts no cycle.
- R10: At most one of ale, read strobe and write strobe is active in any tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, twice the CPU clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write enable for a window's ALE-lengthening setting |
| cfg_win | input | WW | Window whose setting is written |
| cfg_alelong | input | 1 | New setting value: 1 lengthens ALE |
| req | input | 1 | Cycle request, taken only while idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_win | input | WW | Address window of the request |
| req_addr | input | AW | Cycle address |
| req_wdata | input | AW | Write data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-tick completion pulse |
| rdata | output | AW | Read data, valid with done |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| bus_o | output | AW | Shared bus output value |
| bus_oe | output | 1 | Shared bus output enable |
| bus_i | input | AW | Shared bus input value |

## Verification
The bench sweeps every window with both directions, first under the reset settings and then with every setting inverted. It compares each tick of the cycle against a phase schedule computed from the stretch bit. A design that got the stretch wrong would give a 2-tick ALE on window 0 after reset, or would lengthen only ALE and not the hold, so its strobe would start one tick early. Other targeted cases are a configuration flip in the middle of a cycle, which must not change the running cycle, and a request made while busy, which a faulty design would accept. The bench also checks the one-tick write data tail after wr_n rises, which a faulty design would drop or extend, and the read capture edge, which a faulty design would sample after the device stops driving.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW   = 16,
  parameter int NWIN = 4,
  localparam int WW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [WW-1:0] cfg_win,
  input  logic          cfg_alelong,
  input  logic          req,
  input  logic          req_wr,
  input  logic [WW-1:0] req_win,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_wdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] rdata,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [AW-1:0] bus_o,
  output logic          bus_oe,
  input  logic [AW-1:0] bus_i
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_HOLD, S_STRB, S_RECV} st_t;

  st_t           st;
  logic [1:0]    cnt;
  logic          str, wr;
  logic [AW-1:0] addr, wdat;
  logic [NWIN-1:0] alelong;

  wire [1:0] last_idx = ((st == S_ADDR || st == S_HOLD) && str) ? 2'd2 : 2'd1;
  wire       last     = (cnt == last_idx);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      alelong <= NWIN'(1);
    else if (cfg_we) alelong[cfg_win] <= cfg_alelong;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; str <= 1'b0; wr <= 1'b0;
      addr <= '0; wdat <= '0; rdata <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (req) begin
          st   <= S_ADDR;
          cnt  <= '0;
          str  <= alelong[req_win];
          wr   <= req_wr;
          addr <= req_addr;
          wdat <= req_wdata;
        end
      end else if (!last) begin
        cnt <= cnt + 2'd1;
      end else begin
        cnt <= '0;
        case (st)
          S_ADDR: st <= S_HOLD;
          S_HOLD: st <= S_STRB;
          S_STRB: begin
            st <= S_RECV;
            if (!wr) rdata <= bus_i;
          end
          default: begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
        endcase
      end
    end
  end

  assign busy   = (st != S_IDLE);
  assign ale    = (st == S_ADDR);
  assign rd_n   = !(st == S_STRB && !wr);
  assign wr_n   = !(st == S_STRB && wr);
  assign bus_oe = (st == S_ADDR) || (st == S_HOLD) ||
                  (wr && (st == S_STRB || (st == S_RECV && cnt == 2'd0)));
  assign bus_o  = (st == S_ADDR || st == S_HOLD) ? addr : wdat;

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && (!rd_n || !wr_n)) && !(!rd_n && !wr_n));

  assert_ale_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> ($past(ale, 2) && ($past(ale, 3) == str)));

  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe);

  assert_write_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> bus_oe);

  assert_done_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  assert_accept_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> !$past(busy));

endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  localparam int AW = 16;
  localparam int NWIN = 4;
  localparam int WW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_alelong = 1'b0, req = 1'b0, req_wr = 1'b0;
  logic [WW-1:0] cfg_win = '0, req_win = '0;
  logic [AW-1:0] req_addr = '0, req_wdata = '0;
  logic busy, done, ale, rd_n, wr_n, bus_oe;
  logic [AW-1:0] rdata, bus_o, bus_i, lat;
  int checks = 0, errors = 0;
  logic exp_cfg [NWIN];

  always #5 clk = ~clk;

  mux_bus_seq #(.AW(AW), .NWIN(NWIN)) i_mux_bus_seq (
    .clk, .rst_n, .cfg_we, .cfg_win, .cfg_alelong, .req, .req_wr, .req_win,
    .req_addr, .req_wdata, .busy, .done, .rdata, .ale, .rd_n, .wr_n,
    .bus_o, .bus_oe, .bus_i);

  always @(negedge ale) lat <= bus_o;
  assign bus_i = rd_n ? '0 : (lat ^ 16'hA5C3);

  task automatic chk(input logic ok, input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cfg_write(input int w, input logic v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = WW'(w); cfg_alelong = v;
    @(negedge clk);
    cfg_we = 1'b0;
    exp_cfg[w] = v;
  endtask

  // mode 0 plain, 1 flip config mid-cycle (R5), 2 request while busy (R9)
  task automatic run_cycle(input int w, input logic is_wr, input logic [AW-1:0] a, input int mode);
    logic st;
    int A;
    logic [AW-1:0] d;
    st = exp_cfg[w];
    A = st ? 3 : 2;
    d = ~a ^ 16'h0F0F;
    @(negedge clk);
    req = 1'b1; req_wr = is_wr; req_win = WW'(w); req_addr = a; req_wdata = d;
    for (int k = 1; k <= 2*A + 6; k++) begin
      logic e_oe, e_rd, e_wr;
      @(negedge clk);
      if (k == 1) req = 1'b0;
      if (mode == 1 && k == 2) begin cfg_we = 1'b1; cfg_win = WW'(w); cfg_alelong = !st; end
      if (mode == 1 && k == 3) begin cfg_we = 1'b0; exp_cfg[w] = !st; end
      if (mode == 2 && k == 3) begin req = 1'b1; req_addr = a ^ 16'hFFFF; req_wr = !is_wr; end
      if (mode == 2 && k == 4) req = 1'b0;
      chk(ale == (k <= A), st ? "R4 ale" : "R3 ale", AW'(ale), AW'(k <= A));
      e_rd = !is_wr && (k == 2*A+1 || k == 2*A+2);
      e_wr =  is_wr && (k == 2*A+1 || k == 2*A+2);
      chk(rd_n == !e_rd, st ? "R4 rd_n" : "R3 rd_n", AW'(rd_n), AW'(!e_rd));
      chk(wr_n == !e_wr, st ? "R4 wr_n" : "R3 wr_n", AW'(wr_n), AW'(!e_wr));
      e_oe = (k <= 2*A) || (is_wr && k >= 2*A+1 && k <= 2*A+3);
      chk(bus_oe == e_oe, is_wr ? "R7 bus_oe" : "R6 bus_oe", AW'(bus_oe), AW'(e_oe));
      if (k <= 2*A) chk(bus_o == a, "R6 address", bus_o, a);
      else if (e_oe) chk(bus_o == d, "R7 wdata", bus_o, d);
      chk(busy == (k <= 2*A+4) && k != 2*A+6 || (k == 2*A+6 && !busy), "R9 busy", AW'(busy), AW'(k <= 2*A+4));
      chk(done == (k == 2*A+5), "R8 done", AW'(done), AW'(k == 2*A+5));
      if (k == 2*A+5 && !is_wr) chk(rdata == (a ^ 16'hA5C3), "R8 rdata", rdata, a ^ 16'hA5C3);
      if (k == 2*A+6) chk(!ale && !busy, "R9 no extra cycle", AW'(ale), '0);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NWIN; i++) exp_cfg[i] = (i == 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !ale, "R1 idle", AW'({busy, done, ale}), '0);
    chk(rd_n && wr_n && !bus_oe, "R1 strobes", AW'({rd_n, wr_n, bus_oe}), AW'(3'b110));
    // R2 reset settings seen through cycle timing
    for (int w = 0; w < NWIN; w++)
      for (int r = 0; r < 2; r++)
        run_cycle(w, logic'(r), AW'(16'h1234 + w * 16'h0111 + r * 16'h4000), 0);
    for (int w = 0; w < NWIN; w++) cfg_write(w, !exp_cfg[w]);
    for (int w = 0; w < NWIN; w++)
      for (int r = 0; r < 2; r++)
        run_cycle(w, logic'(r), AW'(16'h8C21 + w * 16'h1203 + r * 16'h0040), 0);
    // R5: mid-cycle flip only affects next cycle
    run_cycle(1, 1'b0, 16'h5A5A, 1);
    run_cycle(1, 1'b1, 16'h3C3C, 0);
    run_cycle(2, 1'b1, 16'h0F00, 1);
    run_cycle(2, 1'b0, 16'hF00F, 0);
    // R9: request during busy is dropped
    run_cycle(0, 1'b0, 16'h7777, 2);
    run_cycle(3, 1'b1, 16'h1111, 2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule